// File: doc/BRIEF.md
# Lockable Monotonic Counter

This block keeps a counter that only ever moves upward. It sits behind a small 32-bit register bus with a valid, write, word-address and data interface. Software cannot load a value into the counter. Any write to either of the two counter words adds exactly one to the count, and the data on the bus is thrown away. An increment happens only while an enable bit is set. A soft lock bit or a hard lock bit for the counter freezes both the count and that enable bit.

The count is `LO_W + HI_W` bits wide, 48 by default. The low counter word holds the lower part of the count. The high counter word holds the upper part in its low bits and shows a 16-bit era value from input pins in its bits 31:16.

When the count reaches all ones it stops there, and a sticky rollover flag is raised. The block also holds a 32-bit scratch register with its own soft and hard locks. Every lock bit can only be set: once written to 1 it stays 1 until reset.

Top module: `mono_ctr_top`

## Requirements
- R1: A bus write to the low counter word (address 4) or to the high counter word (address 3) adds exactly one to the count when increments are allowed. The write data never reaches the count.
- R2: The low word (address 4) reads count bits LO_W-1:0, zero-extended. The high word (address 3) reads the upper count bits in bits HI_W-1:0 and `era_in` in bits 31:16. Bus writes never change the era bits, and a carry out of the low part advances the high part.
- R3: The enable bit is bit 0 of the control word (address 0). While it is 0, counter writes leave the count unchanged.
- R4: The lock word is at address 1. Bit 0 is the counter soft lock and bit 2 is the counter hard lock. While either bit is 1, counter writes leave the count unchanged and writes to the control word leave the enable bit unchanged.
- R5: The scratch register (address 5) stores all 32 written bits and reads them back. While lock bit 1 (scratch soft lock) or lock bit 3 (scratch hard lock) is 1, writes to it are ignored.
- R6: Bit 0 of the status word (address 2) is the rollover flag. It reads 0 until the count reaches all ones and is set in the same cycle that the count reaches all ones. From then on the count stays at all ones on further counter writes, and the flag stays 1.
- R7: A lock bit written to 1 stays 1 until reset. Writing 0 to a lock bit that is already set has no effect.
- R8: A synchronous active-high `rst` clears the count, the enable bit, all four lock bits, the rollover flag, the scratch register and `bus_rdata` to 0.
- R9: A read (`bus_valid`=1, `bus_write`=0) puts the addressed word on `bus_rdata` at the next clock edge. Unused bits and addresses 6 and 7 read 0. `bus_rdata` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus transaction request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word address |
| bus_wdata | input | 32 | Write data |
| era_in | input | 16 | Era value shown in the high counter word |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bound checker watches the internal state on every cycle. It checks that the count never falls and never moves by more than one per cycle. It checks that the count holds still while the enable bit is low or a counter lock is set, and that the scratch register holds still while a scratch lock is set. It also checks that lock bits and the rollover flag never clear outside reset, and that a count at all ones always comes with the rollover flag. Other behaviour shows only at the bus, so only the bench scenarios can show it. That covers the word layout and the era pass-through, and the carry from the low part into the high part. It also covers saturation, which the bench reaches through a second, narrow instance. The bench also shows that a blocked write to the enable bit is ignored, and that `bus_rdata` has one cycle of read latency.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int DATA_W   = 32;
  localparam int ERA_W    = 16;
  localparam int LOCK_W   = 4;

  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_LOCK   = 1;
  localparam int A_STAT   = 2;
  localparam int A_CNT_HI = 3;
  localparam int A_CNT_LO = 4;
  localparam int A_SCR    = 5;

  // lock bit positions
  localparam int LK_CTR_SOFT = 0;
  localparam int LK_SCR_SOFT = 1;
  localparam int LK_CTR_HARD = 2;
  localparam int LK_SCR_HARD = 3;
endpackage

// File: rtl/mc_lock_regs.sv
module mc_lock_regs #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lock_q
);
  // set-only bits: a 1 sticks until reset
  always_ff @(posedge clk) begin
    if (rst)     lock_q <= '0;
    else if (wr) lock_q <= lock_q | wdata;
  end
endmodule

// File: rtl/mc_counter.sv
module mc_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump_req,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             locked,
  output logic [CNT_W-1:0] count,
  output logic             enable,
  output logic             rollover
);
  localparam logic [CNT_W-1:0] MAX_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

  logic at_max;
  logic step;

  assign at_max = &count;
  assign step   = bump_req & enable & ~locked & ~at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      enable   <= 1'b0;
      rollover <= 1'b0;
    end else begin
      if (step) count <= count + 1'b1;
      if (step && count == MAX_M1) rollover <= 1'b1;
      if (en_wr && !locked) enable <= en_wdata;
    end
  end
endmodule

// File: rtl/mc_scratch.sv
module mc_scratch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                 value <= '0;
    else if (wr && !locked)  value <= wdata;
  end
endmodule

// File: rtl/mono_ctr_top.sv
module mono_ctr_top #(
  parameter int LO_W   = 32,
  parameter int HI_W   = 16,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [mc_pkg::DATA_W-1:0] bus_wdata,
  input  logic [mc_pkg::ERA_W-1:0]  era_in,
  output logic [mc_pkg::DATA_W-1:0] bus_rdata
);
  import mc_pkg::*;

  localparam int CNT_W = LO_W + HI_W;

  logic              wr_en, rd_en;
  logic              wr_ctrl, wr_lock, wr_scr, wr_cnt;
  logic [CNT_W-1:0]  count;
  logic              enable, rollover;
  logic [LOCK_W-1:0] lock_bits;
  logic              ctr_lock, gp_lock;
  logic [DATA_W-1:0] gpr_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] hi_word, lo_word;

  assign wr_en   = bus_valid & bus_write;
  assign rd_en   = bus_valid & ~bus_write;
  assign wr_ctrl = wr_en && bus_addr == ADDR_W'(A_CTRL);
  assign wr_lock = wr_en && bus_addr == ADDR_W'(A_LOCK);
  assign wr_scr  = wr_en && bus_addr == ADDR_W'(A_SCR);
  assign wr_cnt  = wr_en && (bus_addr == ADDR_W'(A_CNT_HI) ||
                             bus_addr == ADDR_W'(A_CNT_LO));

  assign ctr_lock = lock_bits[LK_CTR_SOFT] | lock_bits[LK_CTR_HARD];
  assign gp_lock  = lock_bits[LK_SCR_SOFT] | lock_bits[LK_SCR_HARD];

  mc_lock_regs #(.W(LOCK_W)) u_lock (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_lock),
    .wdata (bus_wdata[LOCK_W-1:0]),
    .lock_q(lock_bits)
  );

  mc_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .bump_req(wr_cnt),
    .en_wr   (wr_ctrl),
    .en_wdata(bus_wdata[0]),
    .locked  (ctr_lock),
    .count   (count),
    .enable  (enable),
    .rollover(rollover)
  );

  mc_scratch #(.W(DATA_W)) u_scr (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_scr),
    .locked(gp_lock),
    .wdata (bus_wdata),
    .value (gpr_q)
  );

  // word views of the count: upper part in low bits, era in the top half
  assign lo_word = DATA_W'(count[LO_W-1:0]);
  assign hi_word = DATA_W'(count[CNT_W-1:LO_W]) | {era_in, {(DATA_W-ERA_W){1'b0}}};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL):   rd_mux = DATA_W'(enable);
      ADDR_W'(A_LOCK):   rd_mux = DATA_W'(lock_bits);
      ADDR_W'(A_STAT):   rd_mux = DATA_W'(rollover);
      ADDR_W'(A_CNT_HI): rd_mux = hi_word;
      ADDR_W'(A_CNT_LO): rd_mux = lo_word;
      ADDR_W'(A_SCR):    rd_mux = gpr_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count,
  input logic             enable,
  input logic             ctr_lock,
  input logic             gp_lock,
  input logic [3:0]       lock_bits,
  input logic             rollover,
  input logic [31:0]      gpr_q
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_COUNT_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
    armed |-> count >= $past(count)); // R1

  AST_COUNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (count == $past(count) || count == $past(count) + 1'b1)); // R1

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(enable)) |-> count == $past(count)); // R3

  AST_HOLD_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(ctr_lock)) |-> (count == $past(count) && enable == $past(enable))); // R4

  AST_SCRATCH_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(gp_lock)) |-> gpr_q == $past(gpr_q)); // R5

  AST_ROLLOVER_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    (&count) |-> rollover); // R6

  AST_ROLLOVER_STICKY: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rollover)) |-> rollover); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |-> ($past(lock_bits) & ~lock_bits) == 4'b0); // R7
endmodule

bind mono_ctr_top mc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .count    (count),
  .enable   (enable),
  .ctr_lock (ctr_lock),
  .gp_lock  (gp_lock),
  .lock_bits(lock_bits),
  .rollover (rollover),
  .gpr_q    (gpr_q)
);

// File: tb/test_mono_ctr_top.sv
`timescale 1ns/1ps
module test_mono_ctr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] era_in = 16'hA5C3;
  logic [31:0] rdata_def, rdata_sat;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mono_ctr_top i_mono_ctr_top (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .era_in(era_in),
    .bus_rdata(rdata_def)
  );

  // narrow instance: 4-bit low part, 2-bit high part, saturates at 63
  mono_ctr_top #(.LO_W(4), .HI_W(2)) i_mono_ctr_top_sat (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .era_in(era_in),
    .bus_rdata(rdata_sat)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic bump(input int n);
    for (int i = 0; i < n; i++) wr(3'd4, 32'h0);
  endtask

  // {is_read, addr, data, expected} checked on the default instance
  localparam logic [67:0] VEC [13] = '{
    {1'b1, 3'd0, 32'h0,        32'h0},         // R8 enable clear
    {1'b1, 3'd4, 32'h0,        32'h0},         // R8 count clear
    {1'b0, 3'd4, 32'hDEADBEEF, 32'h0},         // R3 write while disabled
    {1'b1, 3'd4, 32'h0,        32'h0},         // R3 no increment
    {1'b0, 3'd0, 32'h1,        32'h0},         // R3 enable
    {1'b1, 3'd0, 32'h0,        32'h1},         // R3 enable reads back
    {1'b0, 3'd4, 32'hFFFFFFFF, 32'h0},         // R1 bump via low word
    {1'b0, 3'd3, 32'h12345678, 32'h0},         // R1 bump via high word
    {1'b1, 3'd4, 32'h0,        32'h2},         // R1 plus one each, data ignored
    {1'b1, 3'd3, 32'h0,        32'hA5C30000},  // R2 era shown, not written
    {1'b0, 3'd5, 32'hCAFEF00D, 32'h0},         // R5 scratch write
    {1'b1, 3'd5, 32'h0,        32'hCAFEF00D},  // R5 scratch read
    {1'b1, 3'd7, 32'h0,        32'h0}          // R9 unmapped reads 0
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R8 rdata after reset", rdata_def, 32'h0);

    foreach (VEC[i]) begin
      if (VEC[i][67]) begin
        rd(VEC[i][66:64]);
        check($sformatf("vector %0d", i), rdata_def, VEC[i][31:0]);
      end else begin
        wr(VEC[i][66:64], VEC[i][63:32]);
      end
    end

    // R9: one-cycle latency and hold
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd5;
    @(posedge clk); #1;
    check("R9 read data after one edge", rdata_def, 32'hCAFEF00D);
    bus_valid = 1'b0; bus_addr = 3'd0;
    repeat (2) @(negedge clk);
    check("R9 rdata holds without read", rdata_def, 32'hCAFEF00D);

    // narrow instance: count is 2, carry into high part at 16 (R2)
    bump(14);
    rd(3'd4); check("R2 narrow low wraps to 0", rdata_sat, 32'h0);
    rd(3'd3); check("R2 narrow high carry", rdata_sat, 32'hA5C30001);
    bump(46);
    rd(3'd2); check("R6 no rollover at 62", rdata_sat, 32'h0);
    rd(3'd4); check("R2 narrow low at 62", rdata_sat, 32'hE);
    bump(1);
    rd(3'd2); check("R6 rollover at max", rdata_sat, 32'h1);
    bump(5);
    rd(3'd4); check("R6 saturated low", rdata_sat, 32'hF);
    rd(3'd3); check("R6 saturated high", rdata_sat, 32'hA5C30003);
    rd(3'd2); check("R6 rollover sticky", rdata_sat, 32'h1);
    rd(3'd4); check("R1 default count 68", rdata_def, 32'd68);
    rd(3'd2); check("R6 default no rollover", rdata_def, 32'h0);

    // soft counter lock (R4) and stickiness (R7)
    wr(3'd1, 32'h1);
    bump(1);
    rd(3'd4); check("R4 soft lock blocks bump", rdata_def, 32'd68);
    wr(3'd0, 32'h0);
    rd(3'd0); check("R4 soft lock blocks enable write", rdata_def, 32'h1);
    wr(3'd1, 32'h0);
    rd(3'd1); check("R7 lock ignores write of 0", rdata_def, 32'h1);
    wr(3'd1, 32'h2);
    wr(3'd5, 32'h0);
    rd(3'd5); check("R5 soft lock blocks scratch", rdata_def, 32'hCAFEF00D);
    rd(3'd1); check("R7 locks accumulate", rdata_def, 32'h3);

    // reset clears everything (R8)
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R8 rdata cleared", rdata_def, 32'h0);
    rd(3'd4); check("R8 count cleared", rdata_def, 32'h0);
    rd(3'd1); check("R8 locks cleared", rdata_def, 32'h0);
    rd(3'd5); check("R8 scratch cleared", rdata_def, 32'h0);
    rd(3'd2); check("R8 rollover cleared", rdata_sat, 32'h0);
    rd(3'd0); check("R8 enable cleared", rdata_def, 32'h0);

    // hard locks (R4, R5)
    wr(3'd0, 32'h1);
    bump(1);
    rd(3'd4); check("R1 bump after reset", rdata_def, 32'h1);
    wr(3'd1, 32'h4);
    wr(3'd3, 32'h0);
    rd(3'd4); check("R4 hard lock blocks bump", rdata_def, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd0); check("R4 hard lock blocks enable write", rdata_def, 32'h1);
    wr(3'd1, 32'h8);
    wr(3'd5, 32'h55AA55AA);
    rd(3'd5); check("R5 hard lock blocks scratch", rdata_def, 32'h0);

    // era follows the pins (R2)
    era_in = 16'h1234;
    rd(3'd3); check("R2 era follows pins", rdata_def, 32'h12340000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule